// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block sits in front of the command scheduler of an SDRAM controller that drives a four-bank mobile SDRAM. Each cycle the scheduler offers at most one decoded command (activate, read, write, single-bank precharge, all-bank precharge, auto refresh or mode register load) together with a bank number and an auto-precharge flag. In the same cycle the guard answers with exactly one of three verdicts. A grant means the command may go to the pins in this cycle. A hold means the command is legal but a spacing rule is still running. A protocol error means the command makes no sense for the current bank state.

The guard keeps one open/idle flag per bank, plus per-bank countdowns for the activate, column and precharge windows. Global countdowns cover activate-to-activate spacing across banks, the quiet period after a mode register load, and the burst window of an auto-precharge column command. All minimum delays are given as nanosecond parameters in picoseconds. At elaboration each is converted to clocks by dividing by the clock period and rounding up. The guard only updates its state on a granted command.

Top module: `sdram_bank_guard`

## Requirements
- R1: Every nanosecond minimum is converted to ceil(t_ps / CLK_PS) clocks. With defaults (7.5 ns clock) an activate is followed by a read or write to the same bank no sooner than ceil(18/7.5)=3 cycles later.
- R2: Two activates to different banks are granted at least ceil(15/7.5)=2 cycles apart.
- R3: For a bank, precharge comes no sooner than 6 cycles after its activate, activate no sooner than 3 cycles after its precharge, and activate no sooner than 9 cycles after its previous activate. A granted activate marks the bank open.
- R4: For a write granted in cycle w, the last data beat is in cycle w+BURST_LEN-1. A precharge to that bank waits until two clocks after that beat, and an activate waits until two clocks plus the precharge time after it.
- R5: Read and write commands to open banks whose activate window has passed are granted in back-to-back cycles.
- R6: Auto refresh (code 5) and mode register load (code 6) are held unless every bank is idle and every bank's activate window has expired.
- R7: After a granted mode register load, no command is granted in the next MRS_CLK-1 cycles (default: the next command comes 2 cycles later).
- R8: A read or write with the auto-precharge flag closes its bank. It blocks every read and write on all banks until BURST_LEN cycles after it. The bank may be re-activated BURST_LEN+tRP cycles after an auto-precharge read, and BURST_LEN-1+2+tRP cycles after an auto-precharge write.
- R9: A read (1) or write (2) to an idle bank, an activate (0) to an open bank, or the reserved code 7 gives a protocol error, no grant, and no change of bank state.
- R10: With a request present, exactly one of grant, hold and protocol error is high. With no request, all three are low. Codes: 0 activate, 1 read, 2 write, 3 precharge bank, 4 precharge all, 5 refresh, 6 mode load, 7 reserved.
- R11: After reset all banks are idle, all windows are expired, and a first activate is granted at once.
- R12: After a granted refresh, an activate to any bank waits the full row cycle time (9 cycles by default).
- R13: Precharge-all waits until every open bank's precharge window has expired, then closes all banks in one step. A precharge to an idle bank is granted without effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is offered this cycle |
| req_cmd | input | 3 | Command code (see R10) |
| req_bank | input | BANK_W | Target bank |
| req_autopre | input | 1 | Auto-precharge flag for read/write |
| grant | output | 1 | Command may issue this cycle |
| hold | output | 1 | Command legal but must wait |
| proto_err | output | 1 | Command illegal for bank state |
| bank_open | output | NUM_BANKS | Per-bank open flag |

## Verification
The hardest situation to create from the ports is one where two windows overlap and the later of them decides the grant cycle. Examples are a precharge bounded by both write recovery and the minimum row-active time, and an activate after an auto-precharge read racing the row-cycle window. The bench offers each command as early as possible and keeps it offered until it is granted. It records the grant cycle and compares the spacing against the maximum of all the applicable windows, computed from the nanosecond figures. Bank pairs and per-bank sequences are swept over all four banks, and state is drained between cases with a precharge-all and idle cycles.

// File: rtl/sdram_guard_pkg.sv
`timescale 1ns/1ps
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    CMD_ACT  = 3'd0,
    CMD_RD   = 3'd1,
    CMD_WR   = 3'd2,
    CMD_PRE  = 3'd3,
    CMD_PREA = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6,
    CMD_RSV  = 3'd7
  } guard_cmd_e;

  // round a picosecond minimum up to whole clocks, never below one
  function automatic int unsigned ps_to_clk(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/guard_bank_timer.sv
`timescale 1ns/1ps
module guard_bank_timer #(
  parameter int unsigned CW         = 4,
  parameter int unsigned L_RCD      = 2,
  parameter int unsigned L_RAS      = 5,
  parameter int unsigned L_RC       = 8,
  parameter int unsigned L_RP       = 2,
  parameter int unsigned L_WR_PRE   = 4,
  parameter int unsigned L_WR_ACT   = 7,
  parameter int unsigned L_RDAP_ACT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic do_rd,
  input  logic do_wr,
  input  logic do_ap,
  input  logic do_pre,
  input  logic do_ref,
  output logic is_open,
  output logic col_ready,
  output logic pre_ready,
  output logic act_ready
);

  localparam logic [CW-1:0] K_RCD      = CW'(L_RCD);
  localparam logic [CW-1:0] K_RAS      = CW'(L_RAS);
  localparam logic [CW-1:0] K_RC       = CW'(L_RC);
  localparam logic [CW-1:0] K_RP       = CW'(L_RP);
  localparam logic [CW-1:0] K_WR_PRE   = CW'(L_WR_PRE);
  localparam logic [CW-1:0] K_WR_ACT   = CW'(L_WR_ACT);
  localparam logic [CW-1:0] K_RDAP_ACT = CW'(L_RDAP_ACT);

  logic          open_q, open_d;
  logic [CW-1:0] col_q, col_d, pre_q, pre_d, act_q, act_d;
  logic          upd_en;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // next-state: countdowns run down, granted commands extend windows
  always_comb begin
    open_d = open_q;
    col_d  = step(col_q);
    pre_d  = step(pre_q);
    act_d  = step(act_q);
    if (do_act) begin
      open_d = 1'b1;
      col_d  = K_RCD;
      pre_d  = mx(pre_d, K_RAS);
      act_d  = mx(act_d, K_RC);
    end
    if (do_wr) begin
      pre_d = mx(pre_d, K_WR_PRE);
      act_d = mx(act_d, K_WR_ACT);
    end
    if (do_rd && do_ap) begin
      act_d = mx(act_d, K_RDAP_ACT);
    end
    if ((do_rd || do_wr) && do_ap) begin
      open_d = 1'b0;
    end
    if (do_pre) begin
      open_d = 1'b0;
      act_d  = mx(act_d, K_RP);
    end
    if (do_ref) begin
      act_d = mx(act_d, K_RC);
    end
  end

  assign upd_en = do_act | do_rd | do_wr | do_pre | do_ref |
                  (|col_q) | (|pre_q) | (|act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      col_q  <= '0;
      pre_q  <= '0;
      act_q  <= '0;
    end else if (upd_en) begin
      open_q <= open_d;
      col_q  <= col_d;
      pre_q  <= pre_d;
      act_q  <= act_d;
    end
  end

  assign is_open   = open_q;
  assign col_ready = (col_q == '0);
  assign pre_ready = (pre_q == '0);
  assign act_ready = (act_q == '0);

endmodule

// File: rtl/guard_global_spacer.sv
`timescale 1ns/1ps
module guard_global_spacer #(
  parameter int unsigned CW    = 4,
  parameter int unsigned L_RRD = 1,
  parameter int unsigned L_MRS = 1,
  parameter int unsigned L_AP  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic do_mrs,
  input  logic do_ap_col,
  output logic rrd_ready,
  output logic mrs_ready,
  output logic col_free
);

  localparam logic [CW-1:0] K_RRD = CW'(L_RRD);
  localparam logic [CW-1:0] K_MRS = CW'(L_MRS);
  localparam logic [CW-1:0] K_AP  = CW'(L_AP);

  logic [CW-1:0] rrd_q, rrd_d, mrs_q, mrs_d, ap_q, ap_d;
  logic          upd_en;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_comb begin
    rrd_d = do_act    ? K_RRD : step(rrd_q);
    mrs_d = do_mrs    ? K_MRS : step(mrs_q);
    ap_d  = do_ap_col ? K_AP  : step(ap_q);
  end

  assign upd_en = do_act | do_mrs | do_ap_col | (|rrd_q) | (|mrs_q) | (|ap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q <= '0;
      mrs_q <= '0;
      ap_q  <= '0;
    end else if (upd_en) begin
      rrd_q <= rrd_d;
      mrs_q <= mrs_d;
      ap_q  <= ap_d;
    end
  end

  assign rrd_ready = (rrd_q == '0);
  assign mrs_ready = (mrs_q == '0);
  assign col_free  = (ap_q == '0);

endmodule

// File: rtl/guard_issue_ctl.sv
`timescale 1ns/1ps
module guard_issue_ctl
  import sdram_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input  logic                 req_valid,
  input  logic [2:0]           req_cmd,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [NUM_BANKS-1:0] open_vec,
  input  logic [NUM_BANKS-1:0] col_rdy,
  input  logic [NUM_BANKS-1:0] pre_rdy,
  input  logic [NUM_BANKS-1:0] act_rdy,
  input  logic                 rrd_rdy,
  input  logic                 mrs_rdy,
  input  logic                 col_free,
  output logic                 grant,
  output logic                 hold,
  output logic                 proto_err
);

  guard_cmd_e cmd;
  logic       sel_open, sel_col, sel_pre, sel_act;
  logic       all_idle, prea_ok;
  logic       illegal, ready;

  assign cmd      = guard_cmd_e'(req_cmd);
  assign sel_open = open_vec[req_bank];
  assign sel_col  = col_rdy[req_bank];
  assign sel_pre  = pre_rdy[req_bank];
  assign sel_act  = act_rdy[req_bank];
  assign all_idle = (~|open_vec) & (&act_rdy);
  assign prea_ok  = &(~open_vec | pre_rdy);

  always_comb begin
    illegal = 1'b0;
    ready   = 1'b0;
    unique case (cmd)
      CMD_ACT: begin
        illegal = sel_open;
        ready   = sel_act & rrd_rdy;
      end
      CMD_RD, CMD_WR: begin
        illegal = ~sel_open;
        ready   = sel_col & col_free;
      end
      CMD_PRE:           ready = ~sel_open | sel_pre;
      CMD_PREA:          ready = prea_ok;
      CMD_REF, CMD_MRS:  ready = all_idle;
      default:           illegal = 1'b1;
    endcase
  end

  assign grant     = req_valid & ~illegal & ready & mrs_rdy;
  assign hold      = req_valid & ~illegal & ~(ready & mrs_rdy);
  assign proto_err = req_valid & illegal;

endmodule

// File: rtl/sdram_bank_guard.sv
`timescale 1ns/1ps
module sdram_bank_guard
  import sdram_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CLK_PS    = 7500,
  parameter int unsigned T_RRD_PS  = 15000,
  parameter int unsigned T_RCD_PS  = 18000,
  parameter int unsigned T_RP_PS   = 18000,
  parameter int unsigned T_RAS_PS  = 45000,
  parameter int unsigned T_RC_PS   = 63000,
  parameter int unsigned WR_CLK    = 2,
  parameter int unsigned MRS_CLK   = 2,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [2:0]           req_cmd,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic                 req_autopre,
  output logic                 grant,
  output logic                 hold,
  output logic                 proto_err,
  output logic [NUM_BANKS-1:0] bank_open
);

  localparam int unsigned RRD_CLK = ps_to_clk(T_RRD_PS, CLK_PS);
  localparam int unsigned RCD_CLK = ps_to_clk(T_RCD_PS, CLK_PS);
  localparam int unsigned RP_CLK  = ps_to_clk(T_RP_PS,  CLK_PS);
  localparam int unsigned RAS_CLK = ps_to_clk(T_RAS_PS, CLK_PS);
  localparam int unsigned RC_CLK  = ps_to_clk(T_RC_PS,  CLK_PS);

  // loads are delay-1: a counter loaded with L frees the command L+1 cycles later
  localparam int unsigned L_RRD      = RRD_CLK - 1;
  localparam int unsigned L_RCD      = RCD_CLK - 1;
  localparam int unsigned L_RP       = RP_CLK - 1;
  localparam int unsigned L_RAS      = RAS_CLK - 1;
  localparam int unsigned L_RC       = RC_CLK - 1;
  localparam int unsigned L_MRS      = MRS_CLK - 1;
  localparam int unsigned L_AP       = BURST_LEN - 1;
  localparam int unsigned L_WR_PRE   = BURST_LEN + WR_CLK - 2;
  localparam int unsigned L_WR_ACT   = BURST_LEN + WR_CLK + RP_CLK - 2;
  localparam int unsigned L_RDAP_ACT = BURST_LEN + RP_CLK - 1;
  localparam int unsigned MAX_LOAD   = umax(umax(umax(L_RC, L_WR_ACT), umax(L_RDAP_ACT, L_RAS)),
                                            umax(umax(L_RRD, L_MRS), L_AP));
  localparam int unsigned CW         = $clog2(MAX_LOAD + 2);

  logic [NUM_BANKS-1:0] col_rdy, pre_rdy, act_rdy;
  logic                 rrd_rdy, mrs_rdy, col_free;
  logic                 g_act, g_rd, g_wr, g_pre, g_prea, g_ref, g_mrs;

  assign g_act  = grant && (req_cmd == CMD_ACT);
  assign g_rd   = grant && (req_cmd == CMD_RD);
  assign g_wr   = grant && (req_cmd == CMD_WR);
  assign g_pre  = grant && (req_cmd == CMD_PRE);
  assign g_prea = grant && (req_cmd == CMD_PREA);
  assign g_ref  = grant && (req_cmd == CMD_REF);
  assign g_mrs  = grant && (req_cmd == CMD_MRS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (req_bank == BANK_W'(b));

    guard_bank_timer #(
      .CW(CW), .L_RCD(L_RCD), .L_RAS(L_RAS), .L_RC(L_RC), .L_RP(L_RP),
      .L_WR_PRE(L_WR_PRE), .L_WR_ACT(L_WR_ACT), .L_RDAP_ACT(L_RDAP_ACT)
    ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_act    (g_act & hit),
      .do_rd     (g_rd & hit),
      .do_wr     (g_wr & hit),
      .do_ap     (req_autopre),
      .do_pre    (((g_pre & hit) | g_prea) & bank_open[b]),
      .do_ref    (g_ref),
      .is_open   (bank_open[b]),
      .col_ready (col_rdy[b]),
      .pre_ready (pre_rdy[b]),
      .act_ready (act_rdy[b])
    );
  end

  guard_global_spacer #(
    .CW(CW), .L_RRD(L_RRD), .L_MRS(L_MRS), .L_AP(L_AP)
  ) u_spacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_act    (g_act),
    .do_mrs    (g_mrs),
    .do_ap_col ((g_rd | g_wr) & req_autopre),
    .rrd_ready (rrd_rdy),
    .mrs_ready (mrs_rdy),
    .col_free  (col_free)
  );

  guard_issue_ctl #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) u_ctl (
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_bank  (req_bank),
    .open_vec  (bank_open),
    .col_rdy   (col_rdy),
    .pre_rdy   (pre_rdy),
    .act_rdy   (act_rdy),
    .rrd_rdy   (rrd_rdy),
    .mrs_rdy   (mrs_rdy),
    .col_free  (col_free),
    .grant     (grant),
    .hold      (hold),
    .proto_err (proto_err)
  );

endmodule

// File: rtl/sdram_bank_guard_checker.sv
`timescale 1ns/1ps
module sdram_bank_guard_checker
  import sdram_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned RRD_CLK   = 2,
  parameter int unsigned MRS_CLK   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [2:0]           req_cmd,
  input logic [BANK_W-1:0]    req_bank,
  input logic                 grant,
  input logic                 hold,
  input logic                 proto_err,
  input logic [NUM_BANKS-1:0] bank_open
);

  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({grant, hold, proto_err}) == 1);

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(grant || hold || proto_err));

  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_cmd == CMD_ACT) |=> bank_open[$past(req_bank)]);

  p_act_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (RRD_CLK > 1 && grant && req_cmd == CMD_ACT) |=> !(grant && req_cmd == CMD_ACT));

  p_refresh_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && (req_cmd == CMD_REF || req_cmd == CMD_MRS)) |-> bank_open == '0);

  p_mrs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (MRS_CLK > 1 && grant && req_cmd == CMD_MRS) |=> !grant);

  p_reopen_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == CMD_ACT && bank_open[req_bank]) |-> proto_err);

  p_err_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> $stable(bank_open));

  p_prea_closes_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req_cmd == CMD_PREA) |=> bank_open == '0);

endmodule

bind sdram_bank_guard sdram_bank_guard_checker #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .RRD_CLK(RRD_CLK), .MRS_CLK(MRS_CLK)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_cmd   (req_cmd),
  .req_bank  (req_bank),
  .grant     (grant),
  .hold      (hold),
  .proto_err (proto_err),
  .bank_open (bank_open)
);

// File: tb/tb_sdram_bank_guard.sv
`timescale 1ns/1ps
module tb_sdram_bank_guard;

  localparam int TCK  = 7500;
  localparam int RRD  = (15000 + TCK - 1) / TCK;
  localparam int RCD  = (18000 + TCK - 1) / TCK;
  localparam int RP   = (18000 + TCK - 1) / TCK;
  localparam int RAS  = (45000 + TCK - 1) / TCK;
  localparam int RC   = (63000 + TCK - 1) / TCK;
  localparam int WRC  = 2;
  localparam int MRSC = 2;
  localparam int BL   = 4;

  localparam logic [2:0] C_ACT = 3'd0, C_RD = 3'd1, C_WR = 3'd2, C_PRE = 3'd3,
                         C_PREA = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_RSV = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [1:0] req_bank = 2'd0;
  logic       req_autopre = 1'b0;
  logic       grant, hold, proto_err;
  logic [3:0] bank_open;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_bank_guard dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_autopre(req_autopre), .grant(grant), .hold(hold),
    .proto_err(proto_err), .bank_open(bank_open)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // offer a command until granted; g = grant cycle, w = cycles held
  task automatic issue(input logic [2:0] c, input int b, input logic ap, output int g, output int w);
    w = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = 2'(b); req_autopre = ap;
    #1;
    while (!grant && w < 60) begin
      @(negedge clk); #1; w++;
    end
    if (!grant) chk("issue timeout", 0, 1);
    g = cyc;
    @(posedge clk); #1;
    req_valid = 1'b0; req_autopre = 1'b0;
  endtask

  // offer a command for one cycle without letting it reach a clock edge
  task automatic probe(input logic [2:0] c, input int b, output logic [2:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_bank = 2'(b); req_autopre = 1'b0;
    #1;
    v = {grant, hold, proto_err};
    #1 req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drain();
    int g, w;
    issue(C_PREA, 0, 1'b0, g, w);
    idle(12);
  endtask

  initial begin
    int g1, g2, g3, g4, w;
    logic [2:0] v;

    idle(3);
    #1;
    chk("R11 reset bank_open", int'(bank_open), 0);
    chk("R10 no request verdicts", int'({grant, hold, proto_err}), 0);
    @(negedge clk) rst_n = 1'b1;

    issue(C_ACT, 0, 1'b0, g1, w);
    chk("R11 first activate waits", w, 0);
    chk("R3 activate opens bank", int'(bank_open), 1);
    drain();

    // R2 sweep over all ordered bank pairs
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          issue(C_ACT, a, 1'b0, g1, w);
          issue(C_ACT, b, 1'b0, g2, w);
          chk("R2 act-act other bank", g2 - g1, RRD);
          drain();
        end
      end
    end

    // R1 activate to column, and R3 row windows, per bank
    for (int b = 0; b < 4; b++) begin
      issue(C_ACT, b, 1'b0, g1, w);
      issue((b % 2) ? C_WR : C_RD, b, 1'b0, g2, w);
      chk("R1 act-col spacing", g2 - g1, RCD);
      drain();
      issue(C_ACT, b, 1'b0, g1, w);
      issue(C_PRE, b, 1'b0, g2, w);
      chk("R3 act-pre spacing", g2 - g1, RAS);
      issue(C_ACT, b, 1'b0, g3, w);
      chk("R3 act-act same bank", g3 - g1, imax(RC, (g2 - g1) + RP));
      drain();
      issue(C_ACT, b, 1'b0, g1, w);
      idle(12);
      issue(C_PRE, b, 1'b0, g2, w);
      issue(C_ACT, b, 1'b0, g3, w);
      chk("R3 pre-act spacing", g3 - g2, RP);
      drain();
    end

    // R4 write recovery, late write and early write
    issue(C_ACT, 1, 1'b0, g1, w);
    idle(8);
    issue(C_WR, 1, 1'b0, g2, w);
    issue(C_PRE, 1, 1'b0, g3, w);
    chk("R4 write-pre spacing", g3 - g2, BL - 1 + WRC);
    issue(C_ACT, 1, 1'b0, g4, w);
    chk("R4 write-act spacing", g4 - g2, imax(BL - 1 + WRC + RP, (g3 - g2) + RP));
    drain();
    issue(C_ACT, 2, 1'b0, g1, w);
    issue(C_WR, 2, 1'b0, g2, w);
    issue(C_PRE, 2, 1'b0, g3, w);
    chk("R4 pre bounded by both windows", g3 - g1, imax(RAS, (g2 - g1) + BL - 1 + WRC));
    drain();

    // R5 column commands every cycle
    issue(C_ACT, 0, 1'b0, g1, w);
    issue(C_ACT, 1, 1'b0, g1, w);
    idle(4);
    issue(C_RD, 0, 1'b0, g1, w);
    issue(C_RD, 1, 1'b0, g2, w);
    chk("R5 rd-rd back to back", g2 - g1, 1);
    issue(C_WR, 0, 1'b0, g3, w);
    chk("R5 rd-wr back to back", g3 - g2, 1);
    issue(C_RD, 1, 1'b0, g4, w);
    chk("R5 wr-rd back to back", g4 - g3, 1);
    drain();

    // R8 auto-precharge read
    issue(C_ACT, 0, 1'b0, g4, w);
    issue(C_ACT, 1, 1'b0, g1, w);
    idle(6);
    issue(C_RD, 0, 1'b1, g1, w);
    chk("R8 ap read closes bank", int'(bank_open), 2);
    probe(C_RD, 0, v);
    chk("R9 read after ap close errs", int'(v), 3'b001);
    issue(C_RD, 1, 1'b0, g2, w);
    chk("R8 column blocked for burst", g2 - g1, BL);
    issue(C_ACT, 0, 1'b0, g3, w);
    chk("R8 ap read reactivate", g3, imax(imax(g1 + BL + RP, g4 + RC), g2 + 1));
    drain();

    // R8 auto-precharge write
    issue(C_ACT, 2, 1'b0, g1, w);
    idle(10);
    issue(C_WR, 2, 1'b1, g1, w);
    chk("R8 ap write closes bank", int'(bank_open), 0);
    issue(C_ACT, 2, 1'b0, g2, w);
    chk("R8 ap write reactivate", g2 - g1, BL - 1 + WRC + RP);
    drain();

    // R9 protocol errors leave state untouched
    probe(C_RD, 1, v);
    chk("R9 read idle bank", int'(v), 3'b001);
    probe(C_WR, 3, v);
    chk("R9 write idle bank", int'(v), 3'b001);
    issue(C_ACT, 1, 1'b0, g1, w);
    idle(10);
    probe(C_ACT, 1, v);
    chk("R9 activate open bank", int'(v), 3'b001);
    probe(C_RSV, 0, v);
    chk("R9 reserved code", int'(v), 3'b001);
    #2;
    chk("R9 state unchanged", int'(bank_open), 2);
    drain();

    // R6 refresh held while a bank is open
    issue(C_ACT, 3, 1'b0, g1, w);
    probe(C_REF, 0, v);
    chk("R6 refresh held", int'(v), 3'b010);
    probe(C_MRS, 0, v);
    chk("R6 mode load held", int'(v), 3'b010);
    issue(C_PREA, 0, 1'b0, g2, w);
    chk("R13 prea waits row active", g2 - g1, RAS);
    issue(C_REF, 0, 1'b0, g3, w);
    chk("R6 refresh after precharge", g3 - g1, imax(RC, (g2 - g1) + RP));

    // R12 refresh then activate, every bank
    for (int b = 0; b < 4; b++) begin
      issue(C_REF, 0, 1'b0, g1, w);
      issue(C_ACT, b, 1'b0, g2, w);
      chk("R12 ref-act spacing", g2 - g1, RC);
      drain();
    end

    // R7 mode load quiet period
    issue(C_MRS, 0, 1'b0, g1, w);
    issue(C_ACT, 0, 1'b0, g2, w);
    chk("R7 mrs-act spacing", g2 - g1, MRSC);
    drain();
    issue(C_MRS, 0, 1'b0, g1, w);
    issue(C_PRE, 1, 1'b0, g2, w);
    chk("R7 mrs-pre spacing", g2 - g1, MRSC);
    chk("R13 idle precharge no effect", int'(bank_open), 0);

    // R13 precharge-all waits for the youngest bank
    issue(C_ACT, 0, 1'b0, g1, w);
    issue(C_ACT, 3, 1'b0, g2, w);
    issue(C_PREA, 0, 1'b0, g3, w);
    chk("R13 prea spacing", g3 - g2, RAS);
    chk("R13 prea closes all", int'(bank_open), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule